// File: doc/BRIEF.md
# Synchronized Output Clock Stop Controller

This block sits between a fast internal CPU clock, a set of slower peripheral clocks derived from it, and the output pins of a system clock generator. It takes two asynchronous active-low requests: one to stop only the CPU-domain clocks, and one to power the whole generator down. Each request passes through a two-flop synchronizer clocked by the CPU clock before it can affect any output. All clock gating is done by enable registers that update on the falling edge of the clock they gate. A gated clock therefore always parks low and always restarts with a full-width high phase.

A CPU stop gates the CPU and SDRAM clock outputs and leaves every peripheral output running. Once the CPU clocks restart, they keep running for a minimum number of cycles even if a new stop request arrives. A power-down request first parks every output low. It then waits a fixed interval and drops the oscillator and PLL enables. While power-down is in effect, the CPU stop request has no effect. When power-down is released, the oscillator and PLL enables come back first, and the outputs stay low for a settle interval. A per-output enable vector can also hold any individual output low at any time.

Top module: `clkstop_ctrl`

## Requirements
- R1: With the CPU stop request asserted (low) between two rising edges, and the minimum-on interval already served, CPU and SDRAM outputs still give a high phase after each of the first three rising edges that follow the request. They give none after the fourth rising edge.
- R2: While the CPU stop is in effect, every peripheral output keeps toggling and the CPU output gives no high phase.
- R3: When the CPU stop request is released (high) between two rising edges, CPU outputs stay low after the third rising edge that follows. They give their first high phase after the fourth.
- R4: Every high phase on a CPU or SDRAM output lasts exactly half a CPU clock period, so no output ever gives a shortened pulse.
- R5: After any restart, CPU outputs give at least MIN_ON (default 100) high phases before they stop for a CPU stop request. If the request is already asserted at restart, they give exactly MIN_ON high phases.
- R6: With the power-down request asserted (low) between rising edges, CPU and SDRAM outputs give a high phase after the third rising edge and none after the fourth. Each peripheral output parks low at its own next falling edge.
- R7: The osc_en and pll_en outputs fall at the rising edge PARK_WAIT (default 16) cycles after parking begins. That is the 19th rising edge after the request, and both enables are still high after the 18th. While the enables are low, every output is low.
- R8: While power-down is in effect, toggling the CPU stop request changes no output.
- R9: When power-down is released (high) between rising edges, osc_en and pll_en are low after the second rising edge and high after the third. CPU outputs stay low for SETTLE (default 20) more cycles and give their first high phase after the 24th rising edge that follows the release.
- R10: Bit i of cpu_en_cfg, sdr_en_cfg or per_en_cfg enables output bit i of cpu_clk_out, sdr_clk_out or per_clk_out. A 0 holds that output low while the other outputs keep running, and setting it back to 1 restores the output.
- R11: While rst_n is low, all clock outputs are low and osc_en and pll_en are high. After reset, the CPU outputs run.
- R12: A power-down request parks the CPU outputs even while the minimum-on interval is still being served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Internal CPU clock; all control logic runs on it |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_stop_req_n | input | 1 | Asynchronous active-low request to stop the CPU and SDRAM outputs |
| pwrdn_req_n | input | 1 | Asynchronous active-low power-down request |
| per_clk_in | input | NPER | Peripheral clocks divided from cpu_clk; their edges fall on CPU falling edges |
| cpu_en_cfg | input | NCPU | Per-output enables for CPU clocks |
| sdr_en_cfg | input | NSDR | Per-output enables for SDRAM clocks |
| per_en_cfg | input | NPER | Per-output enables for peripheral clocks |
| cpu_clk_out | output | NCPU | Gated CPU clock outputs |
| sdr_clk_out | output | NSDR | Gated SDRAM clock outputs |
| per_clk_out | output | NPER | Gated peripheral clock outputs |
| osc_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |

## Verification
Directed sequences place each request edge one nanosecond after a rising edge and sample the outputs in every high phase. This tells a correct three-stage request path apart from one that is a cycle faster or slower. The power-down sequence is walked through end to end. The CPU stop is toggled during the off state, and a power-down is issued inside the minimum-on window, which tells the priority of the two requests apart. A constrained-random phase then toggles the CPU stop request with hold times from one to 150 cycles. The bench checks the length of every CPU run against MIN_ON and the stop and restart latencies against counts kept by the bench. Throughout the run, the bench measures the width of every high pulse.

// File: rtl/clkstop_pkg.sv
// Shared types for the clock stop controller.
package clkstop_pkg;

    // Control sequencer states in the CPU clock domain.
    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,  // all outputs running
        ST_CSTOP  = 3'd1,  // CPU/SDRAM parked, peripherals running
        ST_PARK   = 3'd2,  // all outputs parked, sources still on
        ST_OFF    = 3'd3,  // oscillator and PLL disabled
        ST_SETTLE = 3'd4   // sources back on, outputs still parked
    } ctl_state_e;

endpackage

// File: rtl/req_sync.sv
// Multi-stage synchronizer for one asynchronous active-low request.
// Assumes: the request is a level held for at least two destination cycles.
// The reset value is the inactive level (1).
module req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic sync_n
);
    logic [STAGES-1:0] chain;

    // Shift the raw request through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], async_n};
    end

    assign sync_n = chain[STAGES-1];
endmodule

// File: rtl/stop_fsm.sv
// Control sequencer for the CPU stop and the power-down in the CPU domain.
// Assumes: the requests are already synchronized and active high.
// Outputs: cpu_run enables CPU/SDRAM gates, per_run enables peripheral
// gates, and osc_on drives the oscillator and PLL enables.
module stop_fsm
    import clkstop_pkg::*;
#(
    parameter int MIN_ON    = 100,
    parameter int PARK_WAIT = 16,
    parameter int SETTLE    = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic pd_req,
    output logic cpu_run,
    output logic per_run,
    output logic osc_on
);
    localparam int MAX_A = (MIN_ON > PARK_WAIT) ? MIN_ON : PARK_WAIT;
    localparam int MAX_C = (MAX_A > SETTLE) ? MAX_A : SETTLE;
    localparam int CW    = $clog2(MAX_C + 1);

    ctl_state_e    st;
    logic [CW-1:0] cnt;

    // Advance the sequencer and its shared interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_RUN;
            cnt <= '0;
        end else begin
            case (st)
                ST_RUN: begin
                    if (pd_req) begin
                        st  <= ST_PARK;
                        cnt <= '0;
                    end else if (cnt == CW'(MIN_ON - 1)) begin
                        if (stop_req) st <= ST_CSTOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_CSTOP: begin
                    if (pd_req) begin
                        st  <= ST_PARK;
                        cnt <= '0;
                    end else if (!stop_req) begin
                        st  <= ST_RUN;
                        cnt <= '0;
                    end
                end
                ST_PARK: begin
                    if (cnt == CW'(PARK_WAIT - 1)) begin
                        st  <= ST_OFF;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_OFF: begin
                    if (!pd_req) begin
                        st  <= ST_SETTLE;
                        cnt <= '0;
                    end
                end
                ST_SETTLE: begin
                    if (pd_req) begin
                        st  <= ST_PARK;
                        cnt <= '0;
                    end else if (cnt == CW'(SETTLE - 1)) begin
                        st  <= ST_RUN;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    st  <= ST_RUN;
                    cnt <= '0;
                end
            endcase
        end
    end

    // Decode the gate and source enables from the state.
    always_comb begin
        cpu_run = (st == ST_RUN);
        per_run = (st == ST_RUN) || (st == ST_CSTOP);
        osc_on  = (st != ST_OFF);
    end
endmodule

// File: rtl/clk_gate_neg.sv
// Glitch-free clock gate: the enable is registered on the falling edge of
// the gated clock, so it only changes while that clock is low.
// Assumes: en is stable around falling edges of clk_in.
module clk_gate_neg (
    input  logic clk_in,
    input  logic rst_n,
    input  logic en,
    output logic clk_out
);
    logic en_q;

    // Capture the enable while the clock is low.
    always_ff @(negedge clk_in) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en;
    end

    assign clk_out = clk_in & en_q;
endmodule

// File: rtl/clkstop_ctrl.sv
// Top of the output clock stop controller: synchronizes the two requests,
// sequences stop and power-down, and gates every output clock.
// Assumes: per_clk_in is divided from cpu_clk with edges on CPU falling
// edges, and PARK_WAIT exceeds the slowest peripheral period in cycles.
module clkstop_ctrl #(
    parameter int NCPU        = 2,
    parameter int NSDR        = 4,
    parameter int NPER        = 4,
    parameter int MIN_ON      = 100,
    parameter int PARK_WAIT   = 16,
    parameter int SETTLE      = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic            cpu_clk,
    input  logic            rst_n,
    input  logic            cpu_stop_req_n,
    input  logic            pwrdn_req_n,
    input  logic [NPER-1:0] per_clk_in,
    input  logic [NCPU-1:0] cpu_en_cfg,
    input  logic [NSDR-1:0] sdr_en_cfg,
    input  logic [NPER-1:0] per_en_cfg,
    output logic [NCPU-1:0] cpu_clk_out,
    output logic [NSDR-1:0] sdr_clk_out,
    output logic [NPER-1:0] per_clk_out,
    output logic            osc_en,
    output logic            pll_en
);
    logic stop_sync_n, pd_sync_n;
    logic cpu_run, per_run, osc_on;

    req_sync #(.STAGES(SYNC_STAGES)) u_sync_stop (
        .clk(cpu_clk), .rst_n(rst_n), .async_n(cpu_stop_req_n), .sync_n(stop_sync_n)
    );
    req_sync #(.STAGES(SYNC_STAGES)) u_sync_pd (
        .clk(cpu_clk), .rst_n(rst_n), .async_n(pwrdn_req_n), .sync_n(pd_sync_n)
    );

    stop_fsm #(.MIN_ON(MIN_ON), .PARK_WAIT(PARK_WAIT), .SETTLE(SETTLE)) u_fsm (
        .clk(cpu_clk), .rst_n(rst_n),
        .stop_req(!stop_sync_n), .pd_req(!pd_sync_n),
        .cpu_run(cpu_run), .per_run(per_run), .osc_on(osc_on)
    );

    for (genvar i = 0; i < NCPU; i++) begin : g_cpu
        clk_gate_neg u_gate (
            .clk_in(cpu_clk), .rst_n(rst_n),
            .en(cpu_run & cpu_en_cfg[i]), .clk_out(cpu_clk_out[i])
        );
    end

    for (genvar i = 0; i < NSDR; i++) begin : g_sdr
        clk_gate_neg u_gate (
            .clk_in(cpu_clk), .rst_n(rst_n),
            .en(cpu_run & sdr_en_cfg[i]), .clk_out(sdr_clk_out[i])
        );
    end

    for (genvar i = 0; i < NPER; i++) begin : g_per
        clk_gate_neg u_gate (
            .clk_in(per_clk_in[i]), .rst_n(rst_n),
            .en(per_run & per_en_cfg[i]), .clk_out(per_clk_out[i])
        );
    end

    assign osc_en = osc_on;
    assign pll_en = osc_on;
endmodule

// File: rtl/clkstop_chk.sv
// Property checker for clkstop_ctrl, attached by bind.
// Assumes: the sequencer signals cpu_run and per_run are visible in the top.
module clkstop_chk #(
    parameter int NCPU   = 2,
    parameter int NSDR   = 4,
    parameter int NPER   = 4,
    parameter int MIN_ON = 100
) (
    input logic            cpu_clk,
    input logic            rst_n,
    input logic [NCPU-1:0] cpu_en_cfg,
    input logic [NCPU-1:0] cpu_clk_out,
    input logic [NSDR-1:0] sdr_clk_out,
    input logic [NPER-1:0] per_clk_out,
    input logic            osc_en,
    input logic            cpu_run,
    input logic            per_run
);
    localparam int OCW = $clog2(MIN_ON + 1);
    logic [OCW-1:0] on_cnt;

    // Count cycles the CPU gate enable has been high, saturating.
    always_ff @(posedge cpu_clk) begin
        if (!rst_n)                    on_cnt <= '0;
        else if (!cpu_run)             on_cnt <= '0;
        else if (on_cnt != OCW'(MIN_ON)) on_cnt <= on_cnt + 1'b1;
    end

    AST_MIN_ON_INTERVAL: assert property (@(posedge cpu_clk) disable iff (!rst_n)
        ($fell(cpu_run) && per_run) |-> (on_cnt >= OCW'(MIN_ON))); // R5

    AST_OFF_CPU_LOW: assert property (@(negedge cpu_clk) disable iff (!rst_n)
        !osc_en |-> (cpu_clk_out == '0 && sdr_clk_out == '0)); // R7

    AST_OFF_PER_LOW: assert property (@(posedge cpu_clk) disable iff (!rst_n)
        !osc_en |-> (per_clk_out == '0)); // R7

    AST_OSC_FALL_AFTER_PARK: assert property (@(posedge cpu_clk) disable iff (!rst_n)
        $fell(osc_en) |-> ($past(!per_run) && per_clk_out == '0)); // R7

    AST_OSC_RISE_HELD: assert property (@(posedge cpu_clk) disable iff (!rst_n)
        $rose(osc_en) |-> (!per_run && !cpu_run)); // R9

    AST_CFG_HOLD_LOW: assert property (@(negedge cpu_clk) disable iff (!rst_n)
        (cpu_clk_out & ~$past(cpu_en_cfg)) == '0); // R10
endmodule

bind clkstop_ctrl clkstop_chk #(
    .NCPU(NCPU), .NSDR(NSDR), .NPER(NPER), .MIN_ON(MIN_ON)
) u_chk (
    .cpu_clk(cpu_clk), .rst_n(rst_n), .cpu_en_cfg(cpu_en_cfg),
    .cpu_clk_out(cpu_clk_out), .sdr_clk_out(sdr_clk_out),
    .per_clk_out(per_clk_out), .osc_en(osc_en),
    .cpu_run(cpu_run), .per_run(per_run)
);

// File: tb/sim_clkstop_ctrl.sv
`timescale 1ns/1ps
module sim_clkstop_ctrl;
    localparam int NCPU = 2, NSDR = 4, NPER = 4;
    localparam int MIN_ON = 100, PARK_WAIT = 16, SETTLE = 20;

    logic cpu_clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_stop_req_n = 1'b1;
    logic pwrdn_req_n = 1'b1;
    logic [2:0] dcnt = 3'd0;
    logic [NPER-1:0] per_clk_in;
    logic [NCPU-1:0] cpu_en_cfg = '1;
    logic [NSDR-1:0] sdr_en_cfg = '1;
    logic [NPER-1:0] per_en_cfg = '1;
    logic [NCPU-1:0] cpu_clk_out;
    logic [NSDR-1:0] sdr_clk_out;
    logic [NPER-1:0] per_clk_out;
    logic osc_en, pll_en;

    int checks = 0, failures = 0;
    bit done = 0;
    int pcnt [NPER];
    int snap [NPER];
    int cpu_pulses = 0;
    realtime t_cpu = 0.0, t_sdr = 0.0;
    bit seen_cpu = 0, seen_sdr = 0;

    always #2 cpu_clk = ~cpu_clk;

    // Peripheral clocks divided on CPU falling edges.
    always @(negedge cpu_clk) dcnt <= dcnt + 3'd1;
    assign per_clk_in = {dcnt[0], dcnt[2], ~dcnt[1], dcnt[1]};

    clkstop_ctrl u0 (
        .cpu_clk(cpu_clk), .rst_n(rst_n), .cpu_stop_req_n(cpu_stop_req_n),
        .pwrdn_req_n(pwrdn_req_n), .per_clk_in(per_clk_in),
        .cpu_en_cfg(cpu_en_cfg), .sdr_en_cfg(sdr_en_cfg), .per_en_cfg(per_en_cfg),
        .cpu_clk_out(cpu_clk_out), .sdr_clk_out(sdr_clk_out),
        .per_clk_out(per_clk_out), .osc_en(osc_en), .pll_en(pll_en)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge cpu_clk);
        #1;
    endtask

    // Expected CPU level after a request edge: high up to the given edge.
    function automatic bit exp_high(input int edge_idx, input int last_high);
        return edge_idx <= last_high;
    endfunction

    for (genvar g = 0; g < NPER; g++) begin : g_pc
        always @(posedge per_clk_out[g]) pcnt[g]++;
    end

    // Pulse width monitors for R4.
    always @(posedge cpu_clk_out[0]) begin t_cpu = $realtime; seen_cpu = 1; cpu_pulses++; end
    always @(negedge cpu_clk_out[0]) if (seen_cpu)
        check(($realtime - t_cpu) == 2.0, "R4", int'(($realtime - t_cpu) * 1000.0), 2000);
    always @(posedge sdr_clk_out[0]) begin t_sdr = $realtime; seen_sdr = 1; end
    always @(negedge sdr_clk_out[0]) if (seen_sdr)
        check(($realtime - t_sdr) == 2.0, "R4", int'(($realtime - t_sdr) * 1000.0), 2000);

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int run, hi_age, lo_age, run_at_req, hold, cnt, p0;
        void'($urandom(32'd11));

        // R11: reset state
        repeat (5) tick();
        check(cpu_clk_out == '0 && sdr_clk_out == '0 && per_clk_out == '0, "R11",
              int'({cpu_clk_out, sdr_clk_out, per_clk_out}), 0);
        check(osc_en && pll_en, "R11", int'({osc_en, pll_en}), 3);
        rst_n = 1'b1;
        repeat (3) tick();
        check(cpu_clk_out == '1, "R11", int'(cpu_clk_out), 3);
        repeat (120) tick();

        // R1: stop latency
        cpu_stop_req_n = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            tick();
            check(cpu_clk_out[0] == exp_high(k, 3), "R1", cpu_clk_out[0], exp_high(k, 3));
        end
        check(sdr_clk_out == '0, "R1", int'(sdr_clk_out), 0);

        // R2: peripherals keep running during stop
        for (int i = 0; i < NPER; i++) snap[i] = pcnt[i];
        p0 = cpu_pulses;
        repeat (32) tick();
        for (int i = 0; i < NPER; i++) check(pcnt[i] > snap[i] + 2, "R2", pcnt[i], snap[i] + 3);
        check(cpu_pulses == p0, "R2", cpu_pulses, p0);

        // R3: restart latency
        cpu_stop_req_n = 1'b1;
        for (int k = 1; k <= 4; k++) begin
            tick();
            check(cpu_clk_out[0] == !exp_high(k, 3), "R3", cpu_clk_out[0], !exp_high(k, 3));
        end

        // R5: stop requested right after restart, exactly MIN_ON pulses
        cpu_stop_req_n = 1'b0;
        cnt = 1;
        for (int k = 0; k < 200; k++) begin
            tick();
            if (cpu_clk_out[0]) cnt++;
        end
        check(cnt == MIN_ON, "R5", cnt, MIN_ON);
        cpu_stop_req_n = 1'b1;
        repeat (120) tick();

        // R10: per-output enables
        cpu_en_cfg = 2'b01;
        per_en_cfg = 4'b1011;
        repeat (10) tick();
        for (int i = 0; i < NPER; i++) snap[i] = pcnt[i];
        cnt = 0;
        for (int k = 0; k < 16; k++) begin
            tick();
            if (cpu_clk_out[1] || !cpu_clk_out[0]) cnt++;
        end
        check(cnt == 0, "R10", cnt, 0);
        check(pcnt[2] == snap[2], "R10", pcnt[2], snap[2]);
        check(pcnt[0] > snap[0], "R10", pcnt[0], snap[0] + 1);
        cpu_en_cfg = '1;
        per_en_cfg = '1;
        repeat (16) tick();
        check(cpu_clk_out == 2'b11, "R10", int'(cpu_clk_out), 3);

        // R6/R7: power-down sequence
        pwrdn_req_n = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            tick();
            check(cpu_clk_out[0] == exp_high(k, 3), "R6", cpu_clk_out[0], exp_high(k, 3));
        end
        repeat (9) tick();
        check(per_clk_out == '0, "R6", int'(per_clk_out), 0);
        for (int i = 0; i < NPER; i++) snap[i] = pcnt[i];
        repeat (5) tick();  // at edge 18
        check(osc_en && pll_en, "R7", int'({osc_en, pll_en}), 3);
        for (int i = 0; i < NPER; i++) check(pcnt[i] == snap[i], "R6", pcnt[i], snap[i]);
        tick();             // edge 19
        check(!osc_en && !pll_en, "R7", int'({osc_en, pll_en}), 0);
        check(cpu_clk_out == '0 && per_clk_out == '0, "R7",
              int'({cpu_clk_out, per_clk_out}), 0);

        // R8: stop toggles ignored while down
        cnt = 0;
        for (int k = 0; k < 40; k++) begin
            if (k % 5 == 0) cpu_stop_req_n = ~cpu_stop_req_n;
            tick();
            if (cpu_clk_out != '0 || sdr_clk_out != '0 || per_clk_out != '0 || osc_en) cnt++;
        end
        check(cnt == 0, "R8", cnt, 0);
        cpu_stop_req_n = 1'b1;
        repeat (4) tick();

        // R9: release
        pwrdn_req_n = 1'b1;
        tick(); tick();
        check(!osc_en, "R9", osc_en, 0);
        tick();
        check(osc_en && pll_en, "R9", int'({osc_en, pll_en}), 3);
        repeat (20) tick();
        check(cpu_clk_out[0] == 1'b0, "R9", cpu_clk_out[0], 0);
        tick();
        check(cpu_clk_out[0] == 1'b1, "R9", cpu_clk_out[0], 1);

        // R12: power-down inside the minimum-on window
        repeat (4) tick();
        pwrdn_req_n = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            tick();
            check(cpu_clk_out[0] == exp_high(k, 3), "R12", cpu_clk_out[0], exp_high(k, 3));
        end
        repeat (30) tick();
        pwrdn_req_n = 1'b1;
        repeat (150) tick();

        // Random stop toggling: R1, R3, R5
        run = MIN_ON; hi_age = 0; lo_age = 0; run_at_req = 0;
        for (int it = 0; it < 40; it++) begin
            cpu_stop_req_n = 1'($urandom_range(0, 1));
            hold = $urandom_range(1, 150);
            if (cpu_stop_req_n) lo_age = 0; else begin
                if (lo_age == 0) run_at_req = run;
                hi_age = 0;
            end
            for (int k = 0; k < hold; k++) begin
                tick();
                if (cpu_stop_req_n) hi_age++; else lo_age++;
                if (cpu_stop_req_n && hi_age >= 4)
                    check(cpu_clk_out[0], "R3", cpu_clk_out[0], 1);
                if (!cpu_stop_req_n && lo_age >= 4 && run_at_req >= MIN_ON)
                    check(!cpu_clk_out[0], "R1", cpu_clk_out[0], 0);
                if (cpu_clk_out[0]) run++;
                else begin
                    if (run > 0) check(run >= MIN_ON, "R5", run, MIN_ON);
                    run = 0;
                end
            end
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule